// File: doc/BRIEF.md
# Pad Pull Configuration Register Bank

This block holds the pull setting of every pin in one I/O bank. Each pin owns a 2-bit field that selects no pull, a weak pull-up, a weak pull-down or a bus keeper. Eight pin fields share one 32-bit register, so a bank of `NUM_PINS` pins has `NUM_PINS/8` registers at consecutive word addresses (4 bytes per group of 8 pins). A default 32-pin bank therefore spans 16 bytes.

Each write carries its own bit-level write enable. Bits 31:16 of the write data form a mask, and only the lower data bits whose mask bit is set are stored. Software can therefore change one pin's field with a single write and needs no read-modify-write sequence. Reads return the stored fields in the lower half and zeros in the upper half.

The register contents are decoded into three registered per-pin control vectors for the pad cells: pull-up, pull-down and keeper. A build-time parameter picks how the eight fields are packed in a register. In the ascending packing, pin slot k sits in bits 2k+1:2k. In the mirrored packing, slot k sits in bits 2(7-k)+1:2(7-k).

Top module: `pad_pull_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every field is 00. All of `pull_up`, `pull_down` and `keeper` are 0, and `rdata` is 0.
- R2: On a write, data bit n (n in 0..15) is stored only when `wdata[n+16]` is 1. Every other stored bit keeps its value, so a write with an all-zero mask changes nothing.
- R3: A read presented in cycle t returns `{16'h0, stored word}` on `rdata` after the next clock edge. `rdata` holds its value in cycles with no read.
- R4: Field code 2'b00 drives no control bit. Code 2'b01 sets only `pull_up`, code 2'b10 sets only `pull_down`, and code 2'b11 sets only `keeper`. At most one of the three is 1 for any pin.
- R5: Pin p is held in register p/8, at byte address 4*(p/8). Address bits 1:0 are ignored.
- R6: With `REVERSED`=0, pin slot k (k = p mod 8) uses register bits 2k+1:2k.
- R7: With `REVERSED`=1, pin slot k uses register bits 2(7-k)+1:2(7-k).
- R8: A write presented in cycle t changes the stored word at the edge ending cycle t. The decoded outputs show it one edge later. With no write, the outputs do not change.
- R9: A write whose register index (`addr[ADDR_W-1:2]`) is NUM_PINS/8 or above changes no state. A read at such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | ADDR_W | Byte address; bits ADDR_W-1:2 select the register |
| wdata | input | 32 | Bits 31:16 are the write mask, bits 15:0 are the data |
| rdata | output | 32 | Read result, registered |
| pull_up | output | NUM_PINS | Weak pull-up enable per pin, registered |
| pull_down | output | NUM_PINS | Weak pull-down enable per pin, registered |
| keeper | output | NUM_PINS | Bus keeper enable per pin, registered |

## Verification
The bench drives every input just after a falling edge. It counts rising edges, and each stimulus yields two kinds of result with different latencies. Read data is due at the first rising edge after the read. Decoded pin controls are due two rising edges after the write, because the stored word and the output vectors are separate register stages. The driver tags each expected item with its due cycle. The monitor compares only at the falling edge of that cycle, so an early or late update shows up as a mismatch, including the unchanged outputs expected after ignored writes.

// File: rtl/pad_pull_pkg.sv
// Shared definitions for the pad pull register bank.
// Assumes 8 pins of 2-bit fields per 32-bit register.
package pad_pull_pkg;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_UP   = 2'b01,
        PULL_DOWN = 2'b10,
        PULL_KEEP = 2'b11
    } pull_mode_e;

    localparam int PINS_PER_WORD = 8;
    localparam int FIELD_W       = 2;
    localparam int DATA_W        = PINS_PER_WORD * FIELD_W;

    // Bit position of a pin slot's field inside the 16 data bits.
    function automatic int field_lsb(input int slot, input bit reversed);
        return reversed ? FIELD_W * (PINS_PER_WORD - 1 - slot) : FIELD_W * slot;
    endfunction

endpackage

// File: rtl/pad_pull_word.sv
// One 16-bit pull-setting register with per-bit write enable.
// Assumes the caller has already qualified wr_sel with address and range.
module pad_pull_word
    import pad_pull_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wmask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    // Store only the masked data bits; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_sel) begin
            q <= (q & ~wmask) | (wdata & wmask);
        end
    end

endmodule

// File: rtl/pad_pull_decode.sv
// Decodes the eight pin fields of one register into registered
// pull-up, pull-down and keeper enables. REVERSED picks the field packing.
module pad_pull_decode
    import pad_pull_pkg::*;
#(
    parameter bit REVERSED = 1'b0
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        word,
    output logic [PINS_PER_WORD-1:0] up,
    output logic [PINS_PER_WORD-1:0] down,
    output logic [PINS_PER_WORD-1:0] keep
);

    logic [PINS_PER_WORD-1:0] up_d;
    logic [PINS_PER_WORD-1:0] down_d;
    logic [PINS_PER_WORD-1:0] keep_d;

    for (genvar s = 0; s < PINS_PER_WORD; s++) begin : g_slot
        localparam int LSB = field_lsb(s, REVERSED);
        pull_mode_e mode;
        assign mode      = pull_mode_e'(word[LSB +: FIELD_W]);
        assign up_d[s]   = (mode == PULL_UP);
        assign down_d[s] = (mode == PULL_DOWN);
        assign keep_d[s] = (mode == PULL_KEEP);
    end

    // Register the decoded enables toward the pads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up   <= '0;
            down <= '0;
            keep <= '0;
        end else begin
            up   <= up_d;
            down <= down_d;
            keep <= keep_d;
        end
    end

endmodule

// File: rtl/pad_pull_readback.sv
// Registered readback of the selected register; upper half reads zero.
// Assumes in_range is false whenever idx is at or beyond NUM_REGS.
module pad_pull_readback
    import pad_pull_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 3
)(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic                           in_range,
    input  logic [IDX_W-1:0]               idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] words,
    output logic [31:0]                    rdata
);

    logic [DATA_W-1:0] sel_word;

    // Pick the addressed word, zero when the index is out of range.
    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (in_range && idx == IDX_W'(i)) begin
                sel_word = words[i];
            end
        end
    end

    // Capture read data on a read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= {{(32 - DATA_W){1'b0}}, sel_word};
        end
    end

endmodule

// File: rtl/pad_pull_ctrl.sv
// Top of the pad pull register bank: NUM_PINS/8 masked-write registers,
// readback and registered per-pin pull controls.
// Assumes NUM_PINS is a multiple of 8 and fits in the ADDR_W address space.
module pad_pull_ctrl
    import pad_pull_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter bit REVERSED = 1'b0,
    parameter int ADDR_W   = 5
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic [NUM_PINS-1:0] pull_up,
    output logic [NUM_PINS-1:0] pull_down,
    output logic [NUM_PINS-1:0] keeper
);

    localparam int NUM_REGS = NUM_PINS / PINS_PER_WORD;
    localparam int IDX_W    = ADDR_W - 2;
    localparam logic [IDX_W:0] NUM_REGS_V = (IDX_W + 1)'(NUM_REGS);

    logic [IDX_W-1:0]               idx;
    logic                           in_range;
    logic [NUM_REGS-1:0][DATA_W-1:0] words;
    logic                           unused_addr_lsb;

    assign idx             = addr[ADDR_W-1:2];
    assign in_range        = ({1'b0, idx} < NUM_REGS_V);
    assign unused_addr_lsb = ^addr[1:0];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic [IDX_W-1:0] RI = IDX_W'(r);
        logic wr_sel;
        assign wr_sel = wr_en && in_range && (idx == RI);

        pad_pull_word u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_sel(wr_sel),
            .wmask (wdata[31:16]),
            .wdata (wdata[15:0]),
            .q     (words[r])
        );

        pad_pull_decode #(.REVERSED(REVERSED)) u_dec (
            .clk  (clk),
            .rst_n(rst_n),
            .word (words[r]),
            .up   (pull_up[r*PINS_PER_WORD +: PINS_PER_WORD]),
            .down (pull_down[r*PINS_PER_WORD +: PINS_PER_WORD]),
            .keep (keeper[r*PINS_PER_WORD +: PINS_PER_WORD])
        );
    end

    pad_pull_readback #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .in_range(in_range),
        .idx     (idx),
        .words   (words),
        .rdata   (rdata)
    );

endmodule

// File: rtl/pad_pull_ctrl_chk.sv
// Property checker for pad_pull_ctrl, attached through bind.
// Assumes the same parameter values as the bound instance.
module pad_pull_ctrl_chk #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 5
)(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [31:0]         wdata,
    input logic [31:0]         rdata,
    input logic [NUM_PINS-1:0] pull_up,
    input logic [NUM_PINS-1:0] pull_down,
    input logic [NUM_PINS-1:0] keeper
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W:0] NUM_REGS_V = (IDX_W + 1)'(NUM_PINS / 8);

    logic was_rst;
    logic out_of_range;
    logic unused_chk;

    assign out_of_range = ({1'b0, addr[ADDR_W-1:2]} >= NUM_REGS_V);
    assign unused_chk   = ^{wdata[15:0], addr[1:0]};

    // Remember whether the last edge was a reset edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Outputs and read data must be clear right after a reset edge.
    always @(negedge clk) begin
        if (was_rst) begin
            AST_RESET_CLEAR: assert (pull_up == '0 && pull_down == '0 && keeper == '0 && rdata == '0) // R1
                else $error("reset state not clear");
        end
    end

    AST_ZERO_MASK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[31:16] == 16'h0) |=> ##1 $stable({pull_up, pull_down, keeper})); // R2

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[31:16] == 16'h0); // R3

    AST_ONE_CONTROL_PER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_up & pull_down) | (pull_up & keeper) | (pull_down & keeper)) == '0); // R4

    AST_IDLE_OUTPUTS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !$past(wr_en)) |=> $stable({pull_up, pull_down, keeper})); // R8

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && out_of_range) |=> rdata == 32'h0); // R9

endmodule

bind pad_pull_ctrl pad_pull_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/pad_pull_ctrl_tb_top.sv
// Scoreboard bench: drives one ascending and one mirrored instance with the
// same bus; the driver queues expected results tagged with their due cycle.
module pad_pull_ctrl_tb_top;

    localparam int NP = 32;
    localparam int NR = NP / 8;
    localparam int AW = 5;

    typedef struct {
        int          due;
        logic [31:0] val;
        string       tag;
    } rd_item_t;

    typedef struct {
        int            due;
        logic [NP-1:0] up_n, dn_n, kp_n, up_r, dn_r, kp_r;
        string         tag;
    } out_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata_n, rdata_r;
    logic [NP-1:0] up_n, dn_n, kp_n, up_r, dn_r, kp_r;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [15:0] mdl [NR];
    rd_item_t  rq[$];
    out_item_t oq[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pad_pull_ctrl #(.NUM_PINS(NP), .REVERSED(1'b0), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_n), .pull_up(up_n), .pull_down(dn_n), .keeper(kp_n)
    );

    pad_pull_ctrl #(.NUM_PINS(NP), .REVERSED(1'b1), .ADDR_W(AW)) dut_rev_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_r), .pull_up(up_r), .pull_down(dn_r), .keeper(kp_r)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected control vectors from the model words (R4, R6, R7).
    function automatic logic [NP-1:0] exp_vec(input bit rev, input logic [1:0] code);
        logic [NP-1:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            int k   = p % 8;
            int pos = rev ? 2 * (7 - k) : 2 * k;
            v[p] = (mdl[p / 8][pos +: 2] == code);
        end
        return v;
    endfunction

    task automatic push_out(input int due, input string tag);
        out_item_t it;
        it.due  = due;
        it.tag  = tag;
        it.up_n = exp_vec(1'b0, 2'b01);
        it.dn_n = exp_vec(1'b0, 2'b10);
        it.kp_n = exp_vec(1'b0, 2'b11);
        it.up_r = exp_vec(1'b1, 2'b01);
        it.dn_r = exp_vec(1'b1, 2'b10);
        it.kp_r = exp_vec(1'b1, 2'b11);
        oq.push_back(it);
    endtask

    // Driver: one write in the next cycle; outputs due two edges later.
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        int ri;
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        ri = int'(a[AW-1:2]);
        if (ri < NR) mdl[ri] = (mdl[ri] & ~d[31:16]) | (d[15:0] & d[31:16]);
        push_out(cyc + 2, tag);
    endtask

    // Driver: one read in the next cycle; data due one edge later.
    task automatic do_read(input logic [AW-1:0] a, input string tag);
        rd_item_t it;
        int ri;
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0; wdata = 32'hFFFF_FFFF;
        ri = int'(a[AW-1:2]);
        it.due = cyc + 1;
        it.tag = tag;
        it.val = (ri < NR) ? {16'h0, mdl[ri]} : 32'h0;
        rq.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    task automatic do_reset(input string tag);
        rd_item_t it;
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        for (int i = 0; i < NR; i++) mdl[i] = '0;
        push_out(cyc + 1, tag);
        it.due = cyc + 1; it.val = 32'h0; it.tag = tag;
        rq.push_back(it);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare each queued item in exactly its due cycle.
    always @(negedge clk) begin
        while (rq.size() > 0 && rq[0].due <= cyc) begin
            if (rq[0].due < cyc) check(rq[0].tag, "read missed", 32'h1, 32'h0);
            else begin
                check(rq[0].tag, "rdata ascending", rdata_n, rq[0].val);
                check(rq[0].tag, "rdata mirrored", rdata_r, rq[0].val);
            end
            void'(rq.pop_front());
        end
        while (oq.size() > 0 && oq[0].due <= cyc) begin
            if (oq[0].due < cyc) check(oq[0].tag, "output missed", 32'h1, 32'h0);
            else begin
                check(oq[0].tag, "pull_up ascending", up_n, oq[0].up_n);
                check(oq[0].tag, "pull_down ascending", dn_n, oq[0].dn_n);
                check(oq[0].tag, "keeper ascending", kp_n, oq[0].kp_n);
                check(oq[0].tag, "pull_up mirrored", up_r, oq[0].up_r);
                check(oq[0].tag, "pull_down mirrored", dn_r, oq[0].dn_r);
                check(oq[0].tag, "keeper mirrored", kp_r, oq[0].kp_r);
            end
            void'(oq.pop_front());
        end
    end

    initial begin
        logic [31:0] pat;
        for (int i = 0; i < NR; i++) mdl[i] = '0;
        do_reset("R1 reset state");
        idle(2);
        do_read(5'd0, "R1 read after reset");
        do_write(5'd0, 32'hFFFF_E4E4, "R4 R6 R7 all codes reg0");
        idle(3);
        do_read(5'd0, "R3 readback reg0");
        do_write(5'd1, 32'h000C_FFFF, "R2 mask one field, R5 low addr bits ignored");
        idle(3);
        do_read(5'd2, "R2 R3 masked result");
        do_write(5'd0, 32'h0000_5555, "R2 zero mask");
        idle(3);
        do_read(5'd0, "R2 zero mask readback");
        do_write(5'd12, 32'hFFFF_1B6C, "R5 last register pins 24-31");
        do_write(5'd8, 32'hF00F_A5A5, "R5 reg2 back-to-back");
        idle(3);
        do_write(5'd16, 32'hFFFF_FFFF, "R9 out-of-range write ignored");
        idle(3);
        do_read(5'd16, "R9 out-of-range read");
        do_read(5'd28, "R9 out-of-range read high");
        pat = 32'h1234_5678;
        for (int i = 0; i < 8; i++) begin
            pat = pat * 32'd1103515245 + 32'd12345;
            do_write(AW'((i % NR) * 4), pat, "R8 R6 R7 pattern");
        end
        idle(3);
        for (int i = 0; i < NR; i++) do_read(AW'(i * 4), "R3 R5 sweep");
        idle(2);
        do_reset("R1 reset after use");
        idle(3);
        do_read(5'd12, "R1 read after second reset");
        idle(4);
        if (rq.size() != 0 || oq.size() != 0) check("R8", "queue drained", 32'h1, 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule